// File: doc/BRIEF.md
# Dual-Channel Single-Lane Result Serializer

This block drives the serial output side of a sampling front end with two converters, in the operating mode where both results share one data line. An accepted conversion-start strobe captures a 16-bit result for channel A and one for channel B and marks the block busy. The next two read strobes each send one self-identifying 20-bit frame on lane A: the A frame first, then the B frame. Lane B is never enabled in this mode. A start strobe that arrives while a readout is still in progress is dropped, so a start train running at twice the readout rate loses every second pulse.

A small configuration word can be written with a read strobe. Only alternate read strobes accept a write: the first, third, fifth and so on since reset. A written word waits in a staging register. It becomes the active configuration at the first accepted conversion start that follows at least one further read strobe. Strobes are expected to last one clock. A strobe held high longer is reported on a protocol-error output and acts only once.

Lane outputs come as a data bit plus an output-enable, so the pad logic outside the block builds the high-impedance state.

Top module: `shared_lane_serializer`

## Requirements
- R1: The block responds only when `mode_sel_i` equals 2'b10 (bit 1 high, bit 0 low). With any other value, start and read strobes are ignored, `busy_o` and `sdo_a_oe_o` are low one clock later, and no protocol error is raised.
- R2: `sdo_b_oe_o` and `sdo_b_o` stay low at all times. All frame bits leave on `sdo_a_o`, with `sdo_a_oe_o` high only while a frame is being shifted.
- R3: A frame is 20 bits long and is sent MSB first: a 0, then the channel indicator, then the result from bit 15 down to bit 0, then two 0 bits.
- R4: The first read strobe after an accepted start sends channel A's result with indicator 0. The second sends channel B's result with indicator 1. The first frame bit appears after the clock edge that follows the edge sampling the read strobe, and each later bit appears one clock after the previous one.
- R5: `busy_o` goes high after the edge that accepts a start strobe. It drops after the edge that follows the last bit of the B frame, which is the same edge on which `sdo_a_oe_o` drops.
- R6: A start strobe that arrives while `busy_o` is high is ignored. The results captured by the accepted start are the ones that are sent.
- R7: A read strobe that arrives while the block is idle, or while a frame is armed or shifting, starts no frame.
- R8: A start or read strobe that is high on two consecutive sampled edges raises `proto_err_o` for one clock, after the second edge. The held strobe acts only on its first edge.
- R9: `cfg_wr_i` is honoured only together with the 1st, 3rd, 5th and later odd-numbered in-mode read strobes since reset. On even-numbered read strobes it is dropped.
- R10: An accepted write reaches `cfg_o` only at the first accepted start that comes after at least one further read strobe. It becomes visible after that start's edge.
- R11: While `rst_ni` is low, the block is idle. Both lane enables are low, `proto_err_o` is low, `cfg_o` is zero, the read parity is reset and any pending write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 2 | Mode select, 2'b10 enables the shared-lane mode |
| start_i | input | 1 | Conversion-start strobe, one clock wide |
| read_i | input | 1 | Read strobe, one clock wide |
| res_a_i | input | 16 | Channel A result, captured on accepted start |
| res_b_i | input | 16 | Channel B result, captured on accepted start |
| cfg_wr_i | input | 1 | Configuration write qualifier, sampled with a read strobe |
| cfg_i | input | 4 | Configuration word to write |
| sdo_a_o | output | 1 | Lane A data bit |
| sdo_a_oe_o | output | 1 | Lane A output enable |
| sdo_b_o | output | 1 | Lane B data bit, held low |
| sdo_b_oe_o | output | 1 | Lane B output enable, held low |
| busy_o | output | 1 | Capture held and readout not finished |
| proto_err_o | output | 1 | A strobe was held longer than one clock |
| cfg_o | output | 4 | Active configuration word |

## Verification
The assertions assume that `mode_sel_i` only changes while the block is idle. They also assume that strobes and data inputs change away from the rising edge. The bench drives every input on the falling edge and changes the mode only between transactions, after a reset. Wide strobes are created on purpose, and only in the protocol-error tests. Everywhere else, each strobe is high for exactly one clock, and the two reads of a conversion are spaced so that each read lands after the previous frame has finished.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int unsigned SLS_DATA_W  = 16;
  localparam int unsigned SLS_FRAME_W = 20;
  localparam int unsigned SLS_CFG_W   = 4;
  localparam logic [1:0]  SLS_MODE_SHARED = 2'b10;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/strobe_guard.sv
module strobe_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strb_i,
  output logic pulse_o,
  output logic err_o
);
  logic strb_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      strb_q <= strb_i;
      err_q  <= en_i & strb_i & strb_q;
    end
  end

  assign pulse_o = en_i & strb_i & ~strb_q;
  assign err_o   = err_q;

  // wide strobe flagged one clock after its second sampled edge
  assert_wide_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(strb_i) && $past(strb_i, 2)));

  // a held strobe acts only on its first edge
  assert_single_act_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cfg_pipe.sv
module cfg_pipe #(
  parameter int unsigned CFG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             apply_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic             odd_q;     // high after an odd number of reads
  logic [CFG_W-1:0] pend_q, act_q;
  logic             pend_v_q, pend_rdy_q;
  logic             wr_ok;

  assign wr_ok = rd_i & wr_i & ~odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q      <= 1'b0;
      pend_q     <= '0;
      act_q      <= '0;
      pend_v_q   <= 1'b0;
      pend_rdy_q <= 1'b0;
    end else begin
      if (rd_i) odd_q <= ~odd_q;
      if (apply_i && pend_v_q && pend_rdy_q) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (wr_ok) begin
        pend_q     <= cfg_i;
        pend_v_q   <= 1'b1;
        pend_rdy_q <= 1'b0;
      end else if (rd_i && pend_v_q) begin
        pend_rdy_q <= 1'b1;
      end
    end
  end

  assign cfg_o = act_q;

  assert_cfg_on_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(apply_i));

  assert_ready_needs_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_rdy_q) |-> $past(rd_i));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              ind_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              active_o
);
  localparam int unsigned PAD_W = FRAME_W - 2 - DATA_W;
  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               armed_q, shift_q;

  assign frame = {1'b0, ind_i, data_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      shift_q <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      shift_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i && !armed_q && !shift_q) begin
      sh_q    <= frame;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      shift_q <= 1'b1;
      cnt_q   <= '0;
    end else if (shift_q) begin
      if (cnt_q == LAST) begin
        shift_q <= 1'b0;
      end else begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sdo_o    = shift_q & sh_q[FRAME_W-1];
  assign oe_o     = shift_q;
  assign done_o   = en_i & shift_q & (cnt_q == LAST);
  assign active_o = armed_q | shift_q;

  assert_frame_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q |-> (cnt_q <= LAST));

  assert_oe_after_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(armed_q));

  assert_frame_lead_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !sdo_o);
endmodule

// File: rtl/shared_lane_serializer.sv
module shared_lane_serializer
  import sls_pkg::*;
#(
  parameter int unsigned DATA_W  = SLS_DATA_W,
  parameter int unsigned FRAME_W = SLS_FRAME_W,
  parameter int unsigned CFG_W   = SLS_CFG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_sel_i,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [DATA_W-1:0] res_a_i,
  input  logic [DATA_W-1:0] res_b_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              sdo_a_o,
  output logic              sdo_a_oe_o,
  output logic              sdo_b_o,
  output logic              sdo_b_oe_o,
  output logic              busy_o,
  output logic              proto_err_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic mode_ok;
  logic st_pulse, st_err, rd_pulse, rd_err;
  logic start_acc, rd_frame, sh_done, sh_active;
  logic busy_q;
  side_e side_q;
  logic [DATA_W-1:0] res_a_q, res_b_q;

  assign mode_ok = (mode_sel_i == SLS_MODE_SHARED);

  strobe_guard u_start_guard (
    .clk_i, .rst_ni, .en_i(mode_ok), .strb_i(start_i),
    .pulse_o(st_pulse), .err_o(st_err)
  );

  strobe_guard u_read_guard (
    .clk_i, .rst_ni, .en_i(mode_ok), .strb_i(read_i),
    .pulse_o(rd_pulse), .err_o(rd_err)
  );

  assign start_acc = st_pulse & ~busy_q;
  assign rd_frame  = rd_pulse & busy_q & ~sh_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      side_q  <= SIDE_A;
      res_a_q <= '0;
      res_b_q <= '0;
    end else if (!mode_ok) begin
      busy_q <= 1'b0;
      side_q <= SIDE_A;
    end else if (start_acc) begin
      busy_q  <= 1'b1;
      side_q  <= SIDE_A;
      res_a_q <= res_a_i;
      res_b_q <= res_b_i;
    end else if (sh_done) begin
      if (side_q == SIDE_B) begin
        busy_q <= 1'b0;
        side_q <= SIDE_A;
      end else begin
        side_q <= SIDE_B;
      end
    end
  end

  frame_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shifter (
    .clk_i, .rst_ni,
    .en_i    (mode_ok),
    .load_i  (rd_frame),
    .ind_i   (side_q == SIDE_B),
    .data_i  ((side_q == SIDE_B) ? res_b_q : res_a_q),
    .sdo_o   (sdo_a_o),
    .oe_o    (sdo_a_oe_o),
    .done_o  (sh_done),
    .active_o(sh_active)
  );

  cfg_pipe #(.CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .rd_i   (rd_pulse),
    .wr_i   (cfg_wr_i),
    .cfg_i  (cfg_i),
    .apply_i(start_acc),
    .cfg_o  (cfg_o)
  );

  assign sdo_b_o     = 1'b0;
  assign sdo_b_oe_o  = 1'b0;
  assign busy_o      = busy_q;
  assign proto_err_o = st_err | rd_err;

  assert_mode_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok |=> (!busy_o && !sdo_a_oe_o));

  assert_lane_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_a_oe_o |-> busy_o);

  assert_busy_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_capture_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(res_a_q) && $stable(res_b_q)));
endmodule

// File: tb/shared_lane_serializer_tb_top.sv
module shared_lane_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_sel = 2'b10;
  logic        start = 1'b0, rd = 1'b0, cfg_wr = 1'b0;
  logic [15:0] res_a = '0, res_b = '0;
  logic [3:0]  cfg_in = '0;
  logic        sdo_a, sdo_a_oe, sdo_b, sdo_b_oe, busy, perr;
  logic [3:0]  cfg_out;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shared_lane_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_sel_i(mode_sel),
    .start_i(start), .read_i(rd), .res_a_i(res_a), .res_b_i(res_b),
    .cfg_wr_i(cfg_wr), .cfg_i(cfg_in),
    .sdo_a_o(sdo_a), .sdo_a_oe_o(sdo_a_oe), .sdo_b_o(sdo_b), .sdo_b_oe_o(sdo_b_oe),
    .busy_o(busy), .proto_err_o(perr), .cfg_o(cfg_out)
  );

  localparam logic [31:0] VEC [6] = '{
    32'h0000_FFFF, 32'hFFFF_0000, 32'hA5A5_5A5A,
    32'h8001_7FFE, 32'h1234_FEDC, 32'h0001_8000
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_frame(input logic ind, input logic [15:0] d);
    logic [19:0] f;
    for (int j = 0; j < 20; j++) begin
      logic b;
      if (j == 1) b = ind;
      else if (j >= 2 && j <= 17) b = d[17-j];
      else b = 1'b0;
      f[19-j] = b;
    end
    return f;
  endfunction

  task automatic reset_dut();
    rst_ni = 1'b0; start = 0; rd = 0; cfg_wr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // read strobe, then capture 20 bits; extra_at >= 0 adds a stray read mid-frame
  task automatic read_frame(input bit wr, input logic [3:0] c, input int extra_at,
                            output logic [19:0] bits, output bit lane_ok);
    lane_ok = 1;
    rd = 1'b1; cfg_wr = wr; cfg_in = c;
    @(negedge clk);
    rd = 1'b0; cfg_wr = 1'b0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      bits[19-j] = sdo_a;
      if (!sdo_a_oe || sdo_b_oe || sdo_b) lane_ok = 0;
      rd = (j == extra_at);
    end
    rd = 1'b0;
    @(negedge clk);
    if (sdo_a_oe) lane_ok = 0;
  endtask

  task automatic conv(input logic [15:0] a, input logic [15:0] b,
                      input bit wa, input bit wb, input logic [3:0] c,
                      output logic [19:0] fa, output logic [19:0] fb,
                      output bit ok, output logic [3:0] cfg_at_start);
    bit oka, okb;
    res_a = a; res_b = b;
    pulse_start();
    cfg_at_start = cfg_out;
    @(negedge clk);
    read_frame(wa, c, -1, fa, oka);
    read_frame(wb, c, -1, fb, okb);
    ok = oka & okb;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] fa, fb;
    logic [3:0] cs;
    bit ok;

    // R11: reset state
    repeat (2) @(negedge clk);
    check(!busy && !sdo_a_oe && !sdo_b_oe && !perr && cfg_out == 0, "R11 reset state",
          {busy, sdo_a_oe, sdo_b_oe, perr, cfg_out}, 0);
    reset_dut();

    // vector walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      conv(VEC[i][31:16], VEC[i][15:0], 0, 0, 4'h0, fa, fb, ok, cs);
      check(fa == exp_frame(1'b0, VEC[i][31:16]), "R3 A frame", fa, exp_frame(1'b0, VEC[i][31:16]));
      check(fb == exp_frame(1'b1, VEC[i][15:0]), "R4 B frame", fb, exp_frame(1'b1, VEC[i][15:0]));
      check(ok, "R2 lane use", ok, 1);
      check(!busy, "R5 busy end", busy, 0);
    end

    // R5: busy rises after accepting edge, holds until B frame done
    reset_dut();
    res_a = 16'h0F0F; res_b = 16'hF0F0;
    check(!busy, "R5 idle before start", busy, 0);
    pulse_start();
    check(busy, "R5 busy after start", busy, 1);
    @(negedge clk);
    read_frame(0, 0, -1, fa, ok);
    check(busy, "R5 busy between frames", busy, 1);
    read_frame(0, 0, -1, fb, ok);
    check(!busy && !sdo_a_oe, "R5 busy and oe drop together", {busy, sdo_a_oe}, 0);

    // R6: start during busy ignored
    reset_dut();
    res_a = 16'h1111; res_b = 16'h2222;
    pulse_start();
    @(negedge clk);
    res_a = 16'h3333; res_b = 16'h4444;
    pulse_start();
    @(negedge clk);
    read_frame(0, 0, -1, fa, ok);
    read_frame(0, 0, -1, fb, ok);
    check(fa == exp_frame(0, 16'h1111), "R6 A kept", fa, exp_frame(0, 16'h1111));
    check(fb == exp_frame(1, 16'h2222), "R6 B kept", fb, exp_frame(1, 16'h2222));

    // R7: read while idle starts nothing
    reset_dut();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    repeat (3) @(negedge clk);
    check(!sdo_a_oe && !busy, "R7 idle read", {sdo_a_oe, busy}, 0);

    // R7: read mid-frame ignored, no extra frame after A
    reset_dut();
    res_a = 16'hBEEF; res_b = 16'hCAFE;
    pulse_start();
    @(negedge clk);
    read_frame(0, 0, 5, fa, ok);
    check(fa == exp_frame(0, 16'hBEEF) && ok, "R7 mid-frame read", fa, exp_frame(0, 16'hBEEF));
    @(negedge clk);
    check(!sdo_a_oe && busy, "R7 no extra frame", {sdo_a_oe, busy}, 2'b01);

    // R8: wide start flagged once, acts once
    reset_dut();
    res_a = 16'h0123; res_b = 16'h4567;
    start = 1'b1;
    @(negedge clk);
    check(!perr && busy, "R8 first edge no error", {perr, busy}, 2'b01);
    @(negedge clk);
    start = 1'b0;
    check(perr, "R8 wide start flagged", perr, 1);
    @(negedge clk);
    check(!perr, "R8 error one clock", perr, 0);
    read_frame(0, 0, -1, fa, ok);
    read_frame(0, 0, -1, fb, ok);
    check(fb == exp_frame(1, 16'h4567) && !busy, "R8 wide start acts once", fb, exp_frame(1, 16'h4567));

    // R8: wide read flagged
    reset_dut();
    rd = 1'b1; repeat (2) @(negedge clk); rd = 1'b0;
    check(perr, "R8 wide read flagged", perr, 1);

    // R1: other modes ignore strobes
    foreach (VEC[k]) begin
      if (k < 3) begin
        reset_dut();
        mode_sel = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
        pulse_start();
        @(negedge clk);
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !sdo_a_oe && !perr, "R1 mode gate", {busy, sdo_a_oe, perr}, 0);
        mode_sel = 2'b10;
      end
    end

    // R9: write on 2nd read dropped; write on 1st read accepted
    reset_dut();
    conv(16'h1, 16'h2, 0, 1, 4'h5, fa, fb, ok, cs);
    conv(16'h1, 16'h2, 0, 0, 4'h0, fa, fb, ok, cs);
    check(cs == 4'h0 && cfg_out == 4'h0, "R9 even read write dropped", cfg_out, 0);
    conv(16'h1, 16'h2, 1, 0, 4'h9, fa, fb, ok, cs);
    check(cs == 4'h0, "R10 not active in same conversion", cs, 0);
    conv(16'h1, 16'h2, 0, 0, 4'h0, fa, fb, ok, cs);
    check(cs == 4'h9, "R9 odd read write applied", cs, 4'h9);

    // R10: write with no later read before start is held back
    reset_dut();
    rd = 1'b1; cfg_wr = 1'b1; cfg_in = 4'h3;
    @(negedge clk);
    rd = 1'b0; cfg_wr = 1'b0;
    @(negedge clk);
    conv(16'h7, 16'h8, 0, 0, 4'h0, fa, fb, ok, cs);
    check(cs == 4'h0, "R10 held one read access", cs, 0);
    conv(16'h7, 16'h8, 0, 0, 4'h0, fa, fb, ok, cs);
    check(cs == 4'h3, "R10 applied next start", cs, 4'h3);

    // R11: reset mid-transfer clears everything
    res_a = 16'hFFFF;
    pulse_start();
    @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(!busy && !sdo_a_oe && cfg_out == 0 && !perr, "R11 reset clears",
          {busy, sdo_a_oe, perr, cfg_out}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule